// File: doc/BRIEF.md
# Timestamp and Pulse-Generator Timer Unit

This unit runs from a fixed crystal clock. It keeps a wide timestamp counter that never stops. Three consumers (a tag stamp, an address-translation stamp and a data-path-logging stamp) each read a coarse timestamp. A coarse timestamp is a window of the counter, moved right by a shift amount that software programs for that consumer. The logging stamp can also pass through an external millisecond-based legacy value in place of the counter window.

A common divider makes a timer base from the crystal clock. It divides by one more than the programmed divide value, so a value of 191 gives a ratio of 192. Several pulse generators count periods of that base. Each one issues a single-cycle tick after 100 us, 1 ms or 10 ms worth of base periods, chosen by a 2-bit granularity code per generator. Software reprograms the divider in three writes: clear the enable bit, write the new value with the enable bit clear, then write the same value with the enable bit set.

Configuration arrives on a plain single-cycle register write port with no handshake. All outputs are plain levels or pulses in the crystal clock domain, with no flow control.

Top module: `tsu_timer_unit`

## Requirements
- R1: The timestamp counter is TS_W bits wide (default 56). A synchronous reset clears it to zero, and it then increases by one on every clock edge, wrapping modulo 2^TS_W.
- R2: At address 2, bits [5:0] hold the tag shift and bits [13:8] hold the translation shift. `tag_ts` and `nat_ts` equal the low OUT_W bits of the counter shifted right by that amount, and counter bits past the top read as zero.
- R3: At address 2, bits [21:16] hold the logging shift and bit 24 is the logging select. When the select is 1, `dpl_ts` is the shifted counter slice. When it is 0, `dpl_ts` equals the `legacy_ts` input.
- R4: Writes to the shift fields change only the output slicing. They never disturb the counter's count.
- R5: Address 0 holds the divide value in bits [DIV_W-1:0] and the enable in bit 31. While enabled, a base period lasts value+1 clock cycles, so a generator with a limit of N base periods ticks every N*(value+1) cycles.
- R6: A write to address 0 that arrives while the enable bit is already set updates only the enable bit. The divide value in that write is ignored.
- R7: While the enable bit is clear, no generator ticks. After the edge that sets the bit, the divider and all generators restart from zero, so generator g's first tick appears N_g*(value+1) edges later.
- R8: Address 1 holds one 2-bit granularity code per generator g, in bits [2g+1:2g]. Code 0 selects 10 base periods (100 us), code 1 selects 100 (1 ms), code 2 selects 1000 (10 ms), and the reserved code 3 behaves as code 2.
- R9: A change to a generator's granularity code takes effect at that generator's next period boundary. The period already in progress completes with its old length.
- R10: Every tick is high for exactly one clock cycle.
- R11: After reset, the divider value is 191 and the enable bit is clear. Generator 0 holds code 0, generator 1 holds code 1, and all higher generators hold code 2. The shifts are 14 (tag), 24 (translation) and 14 (logging), and the logging select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W (2) | Register address: 0 divider, 1 granularity codes, 2 stamp shifts |
| wr_data | input | 32 | Register write data |
| legacy_ts | input | OUT_W (32) | Legacy millisecond stamp for the logging consumer |
| tag_ts | output | OUT_W (32) | Coarse tag timestamp |
| nat_ts | output | OUT_W (32) | Coarse address-translation timestamp |
| dpl_ts | output | OUT_W (32) | Coarse data-path-logging timestamp or legacy value |
| tick | output | NUM_GEN (4) | One-cycle tick per pulse generator |

## Verification
The divider is tried at ratios of 2 and 3, under all four granularity codes, and with a code change in the middle of a period. Measured tick spacing separates an off-by-one in the divide ratio from a wrong limit table, and shows whether the reserved code behaves as 10 ms. A divide-value write while enabled, a disabled window and the latency of the first tick after re-enabling separate a divider that ignores the enable rule from one that fails to restart its counts. Shift settings of 0, small values, 40 and 63, together with both logging-select values, check the slicing, the zero fill past the counter's top and the legacy pass-through, and show that shift writes leave the counter's count unchanged.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  typedef enum logic [1:0] {
    GRAN_100US = 2'd0,
    GRAN_1MS   = 2'd1,
    GRAN_10MS  = 2'd2,
    GRAN_RSVD  = 2'd3
  } gran_e;

  localparam int ADDR_DIV   = 0;
  localparam int ADDR_GRAN  = 1;
  localparam int ADDR_STAMP = 2;

  localparam int DIV_EN_BIT   = 31;
  localparam int TAG_SH_LSB   = 0;
  localparam int NAT_SH_LSB   = 8;
  localparam int DPL_SH_LSB   = 16;
  localparam int DPL_SEL_BIT  = 24;
endpackage

// File: rtl/tsu_cfg.sv
module tsu_cfg #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 8,
  parameter int SH_W    = 6,
  parameter int NUM_GEN = 4,
  parameter int DIV_RST = 191,
  parameter int TAG_RST = 14,
  parameter int NAT_RST = 24,
  parameter int DPL_RST = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [DIV_W-1:0]       div_val,
  output logic                   div_en,
  output logic [2*NUM_GEN-1:0]   gran_code,
  output logic [SH_W-1:0]        tag_sh,
  output logic [SH_W-1:0]        nat_sh,
  output logic [SH_W-1:0]        dpl_sh,
  output logic                   dpl_sel
);
  import tsu_pkg::*;

  function automatic logic [2*NUM_GEN-1:0] gran_defaults();
    logic [2*NUM_GEN-1:0] v;
    v = '0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (g == 0)      v[2*g +: 2] = GRAN_100US;
      else if (g == 1) v[2*g +: 2] = GRAN_1MS;
      else             v[2*g +: 2] = GRAN_10MS;
    end
    return v;
  endfunction

  localparam logic [2*NUM_GEN-1:0] GRAN_RST = gran_defaults();

  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_val   <= DIV_W'(DIV_RST);
      div_en    <= 1'b0;
      gran_code <= GRAN_RST;
      tag_sh    <= SH_W'(TAG_RST);
      nat_sh    <= SH_W'(NAT_RST);
      dpl_sh    <= SH_W'(DPL_RST);
      dpl_sel   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(ADDR_DIV): begin
          // value may only be replaced while the divider is stopped
          if (!div_en) div_val <= wr_data[DIV_W-1:0];
          div_en <= wr_data[DIV_EN_BIT];
        end
        ADDR_W'(ADDR_GRAN): gran_code <= wr_data[2*NUM_GEN-1:0];
        ADDR_W'(ADDR_STAMP): begin
          tag_sh  <= wr_data[TAG_SH_LSB +: SH_W];
          nat_sh  <= wr_data[NAT_SH_LSB +: SH_W];
          dpl_sh  <= wr_data[DPL_SH_LSB +: SH_W];
          dpl_sel <= wr_data[DPL_SEL_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsu_stamp.sv
module tsu_stamp #(
  parameter int TS_W  = 56,
  parameter int OUT_W = 32,
  parameter int SH_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SH_W-1:0]   tag_sh,
  input  logic [SH_W-1:0]   nat_sh,
  input  logic [SH_W-1:0]   dpl_sh,
  input  logic              dpl_sel,
  input  logic [OUT_W-1:0]  legacy_ts,
  output logic [TS_W-1:0]   ts,
  output logic [OUT_W-1:0]  tag_ts,
  output logic [OUT_W-1:0]  nat_ts,
  output logic [OUT_W-1:0]  dpl_ts
);
  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

  function automatic logic [OUT_W-1:0] slice(input logic [TS_W-1:0] c,
                                             input logic [SH_W-1:0] s);
    return OUT_W'(c >> s);
  endfunction

  logic [OUT_W-1:0] dpl_slice;

  always_comb begin
    tag_ts    = slice(ts, tag_sh);
    nat_ts    = slice(ts, nat_sh);
    dpl_slice = slice(ts, dpl_sh);
    dpl_ts    = dpl_sel ? dpl_slice : legacy_ts;
  end
endmodule

// File: rtl/tsu_divider.sv
module tsu_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             base_pulse
);
  logic [DIV_W-1:0] cnt;

  assign base_pulse = en && (cnt == div_val);

  always_ff @(posedge clk) begin
    if (rst || !en || base_pulse) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsu_pulse_gen.sv
module tsu_pulse_gen #(
  parameter int LIM0 = 10,
  parameter int LIM1 = 100,
  parameter int LIM2 = 1000,
  parameter int PC_W = $clog2(LIM2 + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       base,
  input  logic [1:0] code,
  output logic       tick
);
  import tsu_pkg::*;

  gran_e            cur;
  logic [PC_W-1:0]  pcnt;
  logic [PC_W-1:0]  last;
  logic             wrap;

  always_comb begin
    case (cur)
      GRAN_100US: last = PC_W'(LIM0 - 1);
      GRAN_1MS:   last = PC_W'(LIM1 - 1);
      default:    last = PC_W'(LIM2 - 1);
    endcase
  end

  assign wrap = base && (pcnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      cur  <= gran_e'(code);
      tick <= 1'b0;
    end else begin
      tick <= en && wrap;
      if (!en) begin
        pcnt <= '0;
        cur  <= gran_e'(code);
      end else if (wrap) begin
        pcnt <= '0;
        cur  <= gran_e'(code);
      end else if (base) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsu_timer_unit.sv
module tsu_timer_unit #(
  parameter int TS_W    = 56,
  parameter int OUT_W   = 32,
  parameter int ADDR_W  = 2,
  parameter int DIV_W   = 8,
  parameter int NUM_GEN = 4,
  parameter int GRAN_L0 = 10,
  parameter int GRAN_L1 = 100,
  parameter int GRAN_L2 = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [OUT_W-1:0]   legacy_ts,
  output logic [OUT_W-1:0]   tag_ts,
  output logic [OUT_W-1:0]   nat_ts,
  output logic [OUT_W-1:0]   dpl_ts,
  output logic [NUM_GEN-1:0] tick
);
  localparam int SH_W = 6;
  localparam int PC_W = $clog2(GRAN_L2 + 1);

  logic [DIV_W-1:0]     div_val;
  logic                 div_en;
  logic [2*NUM_GEN-1:0] gran_code;
  logic [SH_W-1:0]      tag_sh, nat_sh, dpl_sh;
  logic                 dpl_sel;
  logic [TS_W-1:0]      ts_cnt;
  logic                 base_pulse;

  tsu_cfg #(
    .ADDR_W(ADDR_W), .DATA_W(32), .DIV_W(DIV_W), .SH_W(SH_W), .NUM_GEN(NUM_GEN)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_val(div_val), .div_en(div_en), .gran_code(gran_code),
    .tag_sh(tag_sh), .nat_sh(nat_sh), .dpl_sh(dpl_sh), .dpl_sel(dpl_sel)
  );

  tsu_stamp #(.TS_W(TS_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_stamp (
    .clk(clk), .rst(rst), .tag_sh(tag_sh), .nat_sh(nat_sh), .dpl_sh(dpl_sh),
    .dpl_sel(dpl_sel), .legacy_ts(legacy_ts), .ts(ts_cnt),
    .tag_ts(tag_ts), .nat_ts(nat_ts), .dpl_ts(dpl_ts)
  );

  tsu_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(div_en), .div_val(div_val), .base_pulse(base_pulse)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_pgen
    tsu_pulse_gen #(
      .LIM0(GRAN_L0), .LIM1(GRAN_L1), .LIM2(GRAN_L2), .PC_W(PC_W)
    ) u_pg (
      .clk(clk), .rst(rst), .en(div_en), .base(base_pulse),
      .code(gran_code[2*g +: 2]), .tick(tick[g])
    );
  end
endmodule

// File: rtl/tsu_timer_unit_chk.sv
module tsu_timer_unit_chk #(
  parameter int TS_W    = 56,
  parameter int DIV_W   = 8,
  parameter int NUM_GEN = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [TS_W-1:0]    ts,
  input logic               div_en,
  input logic [DIV_W-1:0]   div_val,
  input logic               base_pulse,
  input logic [NUM_GEN-1:0] tick
);
  logic [DIV_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || !div_en || base_pulse) gap <= '0;
    else                              gap <= gap + 1'b1;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ts == TS_W'($past(ts) + 1'b1)));

  p_base_gap_r5: assert property (@(posedge clk) disable iff (rst)
    base_pulse |-> (gap == div_val));

  p_value_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    div_en |=> $stable(div_val));

  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !div_en |=> (tick == '0));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_tick
    p_single_tick_r10: assert property (@(posedge clk) disable iff (rst)
      tick[g] |=> !tick[g]);
  end
endmodule

bind tsu_timer_unit tsu_timer_unit_chk #(
  .TS_W(TS_W), .DIV_W(DIV_W), .NUM_GEN(NUM_GEN)
) u_chk (
  .clk(clk), .rst(rst), .ts(ts_cnt), .div_en(div_en), .div_val(div_val),
  .base_pulse(base_pulse), .tick(tick)
);

// File: tb/tsu_timer_unit_test.sv
module tsu_timer_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] legacy_ts;
  logic [31:0] tag_ts, nat_ts, dpl_ts;
  logic [3:0]  tick;

  always #10 clk = ~clk;

  tsu_timer_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .legacy_ts(legacy_ts), .tag_ts(tag_ts), .nat_ts(nat_ts), .dpl_ts(dpl_ts),
    .tick(tick)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit chk_on = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, derived from R1..R11
  function automatic int lim_of(input int code);
    if (code == 0) return 10;
    if (code == 1) return 100;
    return 1000;
  endfunction

  logic [55:0] ts_m;
  int div_m, divc_m, tag_m, nat_m, dpl_m;
  bit en_m, sel_m, base_m;
  int code_m [4];
  int cur_m  [4];
  int pc_m   [4];
  logic [3:0] exp_tick;
  int cyc = 0;
  int en_edge = 0;
  bit want_first = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ts_m = '0; div_m = 191; en_m = 0; divc_m = 0;
      tag_m = 14; nat_m = 24; dpl_m = 14; sel_m = 0;   // R11 defaults
      for (int g = 0; g < 4; g++) begin
        code_m[g] = (g == 0) ? 0 : (g == 1) ? 1 : 2;
        cur_m[g] = code_m[g]; pc_m[g] = 0;
      end
      exp_tick = '0;
    end else begin
      base_m = en_m && (divc_m == div_m);
      for (int g = 0; g < 4; g++) begin
        exp_tick[g] = base_m && (pc_m[g] == lim_of(cur_m[g]) - 1);
        if (!en_m) begin
          pc_m[g] = 0; cur_m[g] = code_m[g];
        end else if (base_m) begin
          if (pc_m[g] == lim_of(cur_m[g]) - 1) begin
            pc_m[g] = 0; cur_m[g] = code_m[g];
          end else pc_m[g]++;
        end
      end
      if (!en_m || base_m) divc_m = 0; else divc_m++;
      ts_m = ts_m + 1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            if (!en_m) div_m = int'(wr_data[7:0]);
            if (!en_m && wr_data[31]) begin en_edge = cyc; want_first = 1; end
            en_m = wr_data[31];
          end
          2'd1: for (int g = 0; g < 4; g++) code_m[g] = int'(wr_data[2*g +: 2]);
          2'd2: begin
            tag_m = int'(wr_data[5:0]); nat_m = int'(wr_data[13:8]);
            dpl_m = int'(wr_data[21:16]); sel_m = wr_data[24];
          end
          default: ;
        endcase
      end
    end
  end

  int last_t [4] = '{-1, -1, -1, -1};
  int period [4] = '{0, 0, 0, 0};
  int first_lat = 0;
  int tick_cnt = 0;
  logic [3:0] prev_tick = '0;

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(tick == exp_tick, "R5/R7/R8/R9 tick", 64'(tick), 64'(exp_tick));
      check(tag_ts == 32'(ts_m >> tag_m), "R1/R2/R4 tag_ts", 64'(tag_ts),
            64'(32'(ts_m >> tag_m)));
      check(nat_ts == 32'(ts_m >> nat_m), "R2 nat_ts", 64'(nat_ts),
            64'(32'(ts_m >> nat_m)));
      check(dpl_ts == (sel_m ? 32'(ts_m >> dpl_m) : legacy_ts), "R3 dpl_ts",
            64'(dpl_ts), 64'(sel_m ? 32'(ts_m >> dpl_m) : legacy_ts));
      for (int g = 0; g < 4; g++) begin
        if (tick[g] && prev_tick[g])
          check(1'b0, "R10 tick width", 64'(2), 64'(1));
        if (tick[g]) begin
          if (last_t[g] >= 0) period[g] = cyc - last_t[g];
          last_t[g] = cyc;
          tick_cnt++;
        end
      end
      if (tick[0] && want_first) begin
        first_lat = cyc - en_edge;
        want_first = 0;
      end
      prev_tick = tick;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  logic [31:0] snap;

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    legacy_ts = 32'hA5A5_0001;
    @(negedge clk);
    chk_on = 1;
    @(negedge clk);
    // R11: reset state visible at the ports
    check(tick == 4'b0, "R11 reset tick", 64'(tick), 64'(0));
    check(dpl_ts == legacy_ts, "R11 reset dpl select", 64'(dpl_ts), 64'(legacy_ts));
    check(tag_ts == 32'd0, "R1 reset counter", 64'(tag_ts), 64'(0));
    rst = 1'b0;
    repeat (40) @(negedge clk);
    check(tick == 4'b0, "R7 default disabled", 64'(tick), 64'(0));

    // R2 R3: small shifts, logging select on
    wr(2'd2, 32'h0101_0300);
    repeat (50) @(negedge clk);
    // R4: shift write leaves count untouched
    snap = tag_ts;
    wr(2'd2, 32'h0101_0500);
    repeat (9) @(negedge clk);
    check(tag_ts == snap + 32'd10, "R4 counter continuity", 64'(tag_ts),
          64'(snap + 32'd10));

    // R5 R8: divide value 1 -> ratio 2
    wr(2'd0, 32'h0000_0001);
    wr(2'd0, 32'h8000_0001);
    repeat (4500) @(negedge clk);
    check(period[0] == 20,   "R5 gen0 period",  64'(period[0]), 64'(20));
    check(period[1] == 200,  "R8 gen1 period",  64'(period[1]), 64'(200));
    check(period[2] == 2000, "R8 gen2 period",  64'(period[2]), 64'(2000));
    check(first_lat == 20,   "R7 first tick",   64'(first_lat), 64'(20));

    // R6: value write while enabled ignored
    wr(2'd0, 32'h8000_0004);
    repeat (100) @(negedge clk);
    check(period[0] == 20, "R6 value ignored", 64'(period[0]), 64'(20));

    // R9 R8: new codes mid-period, reserved code on gen3
    wr(2'd1, 32'h0000_00E5);
    repeat (4500) @(negedge clk);
    check(period[0] == 200,  "R9 gen0 new code", 64'(period[0]), 64'(200));
    check(period[3] == 2000, "R8 reserved code", 64'(period[3]), 64'(2000));

    // R7: disabled window, reprogram, restart latency
    wr(2'd0, 32'h0000_0000);
    wr(2'd0, 32'h0000_0002);
    tick_cnt = 0;
    repeat (3000) @(negedge clk);
    check(tick_cnt == 0, "R7 no ticks while off", 64'(tick_cnt), 64'(0));
    wr(2'd0, 32'h8000_0002);
    repeat (2500) @(negedge clk);
    check(first_lat == 300, "R7 restart latency", 64'(first_lat), 64'(300));
    check(period[0] == 300, "R5 ratio 3 period", 64'(period[0]), 64'(300));

    // R2 R3: large shifts, legacy source
    legacy_ts = 32'h1234_5678;
    wr(2'd2, 32'h003F_283F);
    repeat (20) @(negedge clk);
    check(tag_ts == 32'd0, "R2 shift 63 zero fill", 64'(tag_ts), 64'(0));
    check(dpl_ts == 32'h1234_5678, "R3 legacy pass", 64'(dpl_ts), 64'(32'h1234_5678));
    finish_run();
  end
endmodule